// File: doc/BRIEF.md
# Translation descriptor hardware updater

This block sits beside a page-table walker and handles the last step of a walk: deciding whether a fetched leaf descriptor must be modified by hardware, and doing that modification safely. It is given the descriptor, the walk's inner and outer cacheability attributes, the translation stage, the access direction and, for each stage, an enable for access-flag management and an enable for dirty-state management. It also tells the walker whether table reads for the current attributes may be served from the data cache or must go to external memory.

When the descriptor needs a change, the block builds the new value and issues one atomic compare-and-swap request. The compare value is the descriptor as originally read. A failed compare is reported as a retry, so the walker re-reads and re-evaluates. When nothing needs to change, the block completes without any memory write. Instead of updating, it can end an evaluation with a fault status and a 6-bit fault code: a missing access flag that hardware may not set, a write to an entry that cannot be made writable, or an update requested in memory that is not Write-Back at both cacheability levels.

Top module: `pte_hw_updater`

## Requirements
- R1: `walk_from_cache` is 1 exactly when both `inner_attr` and `outer_attr` are Write-Back. The attribute encoding is 2'b00 Non-cacheable, 2'b01 Write-Back with write-allocate, 2'b10 Write-Through and 2'b11 Write-Back without write-allocate.
- R2: If the selected stage's access-flag enable is set and descriptor bit 10 (access flag) is 0, a compare-and-swap is issued. Its compare value is the original descriptor and its swap value has bit 10 set.
- R3: If descriptor bit 10 is 0 and the selected stage's access-flag enable is clear, the evaluation ends with status FAULT (2'd2) and code 6'b001011, and no request is issued. Only the enables of the stage given by `stage2` are used.
- R4: At stage 1 (`stage2`=0), a write to an entry with bit 7 = 1 (read-only) and bit 51 = 1 (dirty-bit modifier), with dirty management in effect, produces a swap value with bit 7 cleared.
- R5: At stage 2, a write to an entry with bit 7 = 0 (no write permission) and bit 51 = 1, with dirty management in effect, produces a swap value with bit 7 set.
- R6: The dirty-state enable of a stage has no effect unless the access-flag enable of the same stage is also set.
- R7: A write to a non-writable entry that cannot be marked dirty ends with status FAULT and code 6'b001111, and no request is issued.
- R8: If an update is needed and either attribute is not Write-Back, the evaluation ends with status FAULT and code 6'b110001, and no request is issued.
- R9: When no descriptor bit needs to change, the evaluation ends with status OK (2'd0), `result_desc` equal to the input descriptor, and no request.
- R10: A compare-and-swap response with a match gives status OK and `result_desc` equal to the swap value. A mismatch gives status RETRY (2'd1) and `result_desc` equal to the original descriptor.
- R11: `cas_valid` and the request values hold steady until `cas_ready`. `eval_ready` is 0 from acceptance until the cycle after `done_valid`, so at most one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_valid | input | 1 | Descriptor presented for evaluation |
| eval_ready | output | 1 | Block idle, evaluation accepted |
| desc_in | input | 64 | Fetched leaf descriptor |
| inner_attr | input | 2 | Inner cacheability of walk memory |
| outer_attr | input | 2 | Outer cacheability of walk memory |
| stage2 | input | 1 | 1 = stage 2 translation, 0 = stage 1 |
| is_write | input | 1 | Access is a write |
| af_en_s1 | input | 1 | Stage 1 access-flag management enable |
| dirty_en_s1 | input | 1 | Stage 1 dirty-state management enable |
| af_en_s2 | input | 1 | Stage 2 access-flag management enable |
| dirty_en_s2 | input | 1 | Stage 2 dirty-state management enable |
| walk_from_cache | output | 1 | Walk reads use data-cache lookup |
| cas_valid | output | 1 | Compare-and-swap request valid |
| cas_ready | input | 1 | Request accepted by memory side |
| cas_compare | output | 64 | Expected current descriptor value |
| cas_swap | output | 64 | New descriptor value |
| cas_resp_valid | input | 1 | Compare-and-swap completion |
| cas_resp_match | input | 1 | Compare succeeded |
| done_valid | output | 1 | One-cycle evaluation completion pulse |
| done_status | output | 2 | 0 OK, 1 RETRY, 2 FAULT |
| fault_code | output | 6 | Fault status code when FAULT |
| result_desc | output | 64 | Final descriptor value |

## Verification
A wrong decision state shows up as a missing or extra compare-and-swap request one cycle after acceptance, or as a wrong status or code on the `done_valid` pulse. That pulse follows one cycle after acceptance on the no-write paths, and one cycle after the response on the update path. A corrupted held request shows as `cas_swap` changing, or `cas_valid` dropping, during a stall before `cas_ready`. A stuck busy state shows as `eval_ready` staying low after the completion pulse.

// File: rtl/pte_upd_pkg.sv
package pte_upd_pkg;
  localparam int DESC_W = 64;
  localparam int ATTR_W = 2;
  localparam int CODE_W = 6;

  typedef enum logic [1:0] {
    UPD_OK    = 2'd0,
    UPD_RETRY = 2'd1,
    UPD_FAULT = 2'd2
  } upd_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } upd_state_e;

  localparam logic [CODE_W-1:0] FSC_ACCESS = 6'b001011;
  localparam logic [CODE_W-1:0] FSC_PERM   = 6'b001111;
  localparam logic [CODE_W-1:0] FSC_UNSUP  = 6'b110001;
endpackage

// File: rtl/pte_wb_check.sv
module pte_wb_check #(
  parameter int ATTR_W = 2,
  parameter int N_LVL  = 2
) (
  input  logic [N_LVL*ATTR_W-1:0] attrs,
  output logic                    all_wb
);
  logic [N_LVL-1:0] lvl_wb;

  // Write-Back encodings are the two with the low bit set.
  for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
    assign lvl_wb[g] = attrs[g*ATTR_W];
  end

  assign all_wb = &lvl_wb;
endmodule

// File: rtl/pte_update_calc.sv
module pte_update_calc
  import pte_upd_pkg::*;
#(
  parameter int DESC_W  = 64,
  parameter int AF_BIT  = 10,
  parameter int DBM_BIT = 51,
  parameter int WP_BIT  = 7
) (
  input  logic [DESC_W-1:0] desc,
  input  logic              stage2,
  input  logic              is_write,
  input  logic              af_en_s1,
  input  logic              dirty_en_s1,
  input  logic              af_en_s2,
  input  logic              dirty_en_s2,
  input  logic              both_wb,
  output logic              need_write,
  output logic              fault,
  output logic [CODE_W-1:0] fault_code,
  output logic [DESC_W-1:0] new_desc
);
  logic af_en_sel, dirty_sel, writable, af_missing, mark_dirty;

  always_comb begin
    af_en_sel  = stage2 ? af_en_s2 : af_en_s1;
    dirty_sel  = (stage2 ? dirty_en_s2 : dirty_en_s1) & af_en_sel;
    writable   = stage2 ? desc[WP_BIT] : ~desc[WP_BIT];
    af_missing = ~desc[AF_BIT];
    mark_dirty = is_write & ~writable & dirty_sel & desc[DBM_BIT];

    new_desc = desc;
    if (af_missing && af_en_sel) new_desc[AF_BIT] = 1'b1;
    if (mark_dirty)              new_desc[WP_BIT] = stage2;
    need_write = (new_desc != desc);

    fault      = 1'b0;
    fault_code = '0;
    if (af_missing && !af_en_sel) begin
      fault      = 1'b1;
      fault_code = FSC_ACCESS;
    end else if (is_write && !writable && !mark_dirty) begin
      fault      = 1'b1;
      fault_code = FSC_PERM;
    end else if (need_write && !both_wb) begin
      fault      = 1'b1;
      fault_code = FSC_UNSUP;
    end
  end
endmodule

// File: rtl/pte_cas_fsm.sv
module pte_cas_fsm
  import pte_upd_pkg::*;
#(
  parameter int DESC_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_valid,
  input  logic [DESC_W-1:0] desc,
  input  logic [DESC_W-1:0] new_desc,
  input  logic              need_write,
  input  logic              fault,
  input  logic [CODE_W-1:0] fault_code_in,
  input  logic              cas_ready,
  input  logic              cas_resp_valid,
  input  logic              cas_resp_match,
  output logic              eval_ready,
  output logic              cas_valid,
  output logic [DESC_W-1:0] cas_compare,
  output logic [DESC_W-1:0] cas_swap,
  output logic              done_valid,
  output logic [1:0]        done_status,
  output logic [CODE_W-1:0] fault_code,
  output logic [DESC_W-1:0] result_desc
);
  upd_state_e        state_q, state_d;
  logic              load_en, resp_en;
  logic [DESC_W-1:0] cmp_q, swp_q, out_q;
  upd_status_e       stat_q;
  logic [CODE_W-1:0] code_q;

  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    resp_en = 1'b0;
    case (state_q)
      S_IDLE: if (eval_valid) begin
        load_en = 1'b1;
        state_d = (need_write && !fault) ? S_REQ : S_DONE;
      end
      S_REQ:  if (cas_ready) state_d = S_WAIT;
      S_WAIT: if (cas_resp_valid) begin
        resp_en = 1'b1;
        state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      swp_q  <= '0;
      out_q  <= '0;
      stat_q <= UPD_OK;
      code_q <= '0;
    end else if (load_en) begin
      cmp_q  <= desc;
      swp_q  <= new_desc;
      out_q  <= fault ? desc : new_desc;
      stat_q <= fault ? UPD_FAULT : UPD_OK;
      code_q <= fault ? fault_code_in : '0;
    end else if (resp_en) begin
      out_q  <= cas_resp_match ? swp_q : cmp_q;
      stat_q <= cas_resp_match ? UPD_OK : UPD_RETRY;
    end
  end

  assign eval_ready  = (state_q == S_IDLE);
  assign cas_valid   = (state_q == S_REQ);
  assign cas_compare = cmp_q;
  assign cas_swap    = swp_q;
  assign done_valid  = (state_q == S_DONE);
  assign done_status = stat_q;
  assign fault_code  = code_q;
  assign result_desc = out_q;
endmodule

// File: rtl/pte_hw_updater.sv
module pte_hw_updater
  import pte_upd_pkg::*;
#(
  parameter int DESC_W  = 64,
  parameter int ATTR_W  = 2,
  parameter int AF_BIT  = 10,
  parameter int DBM_BIT = 51,
  parameter int WP_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_valid,
  output logic              eval_ready,
  input  logic [DESC_W-1:0] desc_in,
  input  logic [ATTR_W-1:0] inner_attr,
  input  logic [ATTR_W-1:0] outer_attr,
  input  logic              stage2,
  input  logic              is_write,
  input  logic              af_en_s1,
  input  logic              dirty_en_s1,
  input  logic              af_en_s2,
  input  logic              dirty_en_s2,
  output logic              walk_from_cache,
  output logic              cas_valid,
  input  logic              cas_ready,
  output logic [DESC_W-1:0] cas_compare,
  output logic [DESC_W-1:0] cas_swap,
  input  logic              cas_resp_valid,
  input  logic              cas_resp_match,
  output logic              done_valid,
  output logic [1:0]        done_status,
  output logic [5:0]        fault_code,
  output logic [DESC_W-1:0] result_desc
);
  localparam int N_LVL = 2;

  logic              both_wb, need_write, fault;
  logic [CODE_W-1:0] calc_code;
  logic [DESC_W-1:0] new_desc;

  pte_wb_check #(.ATTR_W(ATTR_W), .N_LVL(N_LVL)) u_wb (
    .attrs  ({outer_attr, inner_attr}),
    .all_wb (both_wb)
  );

  assign walk_from_cache = both_wb;

  pte_update_calc #(
    .DESC_W(DESC_W), .AF_BIT(AF_BIT), .DBM_BIT(DBM_BIT), .WP_BIT(WP_BIT)
  ) u_calc (
    .desc        (desc_in),
    .stage2      (stage2),
    .is_write    (is_write),
    .af_en_s1    (af_en_s1),
    .dirty_en_s1 (dirty_en_s1),
    .af_en_s2    (af_en_s2),
    .dirty_en_s2 (dirty_en_s2),
    .both_wb     (both_wb),
    .need_write  (need_write),
    .fault       (fault),
    .fault_code  (calc_code),
    .new_desc    (new_desc)
  );

  pte_cas_fsm #(.DESC_W(DESC_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .eval_valid     (eval_valid),
    .desc           (desc_in),
    .new_desc       (new_desc),
    .need_write     (need_write),
    .fault          (fault),
    .fault_code_in  (calc_code),
    .cas_ready      (cas_ready),
    .cas_resp_valid (cas_resp_valid),
    .cas_resp_match (cas_resp_match),
    .eval_ready     (eval_ready),
    .cas_valid      (cas_valid),
    .cas_compare    (cas_compare),
    .cas_swap       (cas_swap),
    .done_valid     (done_valid),
    .done_status    (done_status),
    .fault_code     (fault_code),
    .result_desc    (result_desc)
  );
endmodule

// File: rtl/pte_hw_updater_chk.sv
module pte_hw_updater_chk #(
  parameter int DESC_W = 64,
  parameter int AF_BIT = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eval_ready,
  input logic              cas_valid,
  input logic              cas_ready,
  input logic [DESC_W-1:0] cas_compare,
  input logic [DESC_W-1:0] cas_swap,
  input logic              done_valid,
  input logic [1:0]        done_status,
  input logic [5:0]        fault_code
);
  AST_CAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid && !cas_ready |=> cas_valid && $stable(cas_swap) && $stable(cas_compare)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> !eval_ready); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && eval_ready); // R11
  AST_SWAP_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> cas_swap != cas_compare); // R9
  AST_SWAP_HAS_AF: assert property (@(posedge clk) disable iff (!rst_n)
    cas_valid |-> cas_swap[AF_BIT]); // R2
  AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_status == 2'd2 |->
      fault_code == 6'b001011 || fault_code == 6'b001111 || fault_code == 6'b110001); // R3 R7 R8
endmodule

bind pte_hw_updater pte_hw_updater_chk #(.DESC_W(DESC_W), .AF_BIT(AF_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eval_ready  (eval_ready),
  .cas_valid   (cas_valid),
  .cas_ready   (cas_ready),
  .cas_compare (cas_compare),
  .cas_swap    (cas_swap),
  .done_valid  (done_valid),
  .done_status (done_status),
  .fault_code  (fault_code)
);

// File: tb/pte_hw_updater_bench.sv
`timescale 1ns/1ps
module pte_hw_updater_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_valid = 1'b0;
  logic        eval_ready;
  logic [63:0] desc_in = '0;
  logic [1:0]  inner_attr = 2'b01, outer_attr = 2'b01;
  logic        stage2 = 1'b0, is_write = 1'b0;
  logic        af_en_s1 = 1'b0, dirty_en_s1 = 1'b0, af_en_s2 = 1'b0, dirty_en_s2 = 1'b0;
  logic        walk_from_cache, cas_valid;
  logic        cas_ready = 1'b0;
  logic [63:0] cas_compare, cas_swap;
  logic        cas_resp_valid = 1'b0, cas_resp_match = 1'b0;
  logic        done_valid;
  logic [1:0]  done_status;
  logic [5:0]  fault_code;
  logic [63:0] result_desc;

  int n_checks = 0;
  int n_fail = 0;

  localparam logic [63:0] BASE = 64'h0000_0000_4000_0003;
  localparam logic [63:0] AF   = 64'd1 << 10;
  localparam logic [63:0] DBM  = 64'd1 << 51;
  localparam logic [63:0] WP   = 64'd1 << 7;

  always #2.5 clk = ~clk;

  pte_hw_updater u_pte_hw_updater (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [1:0] ia, input logic [1:0] oa, input logic s2, input logic wr,
                         input logic a1, input logic d1, input logic a2, input logic d2);
    inner_attr = ia; outer_attr = oa; stage2 = s2; is_write = wr;
    af_en_s1 = a1; dirty_en_s1 = d1; af_en_s2 = a2; dirty_en_s2 = d2;
  endtask

  // Present one descriptor, serve the memory side, check the outcome.
  task automatic run_case(input string req, input logic [63:0] d, input bit match, input int stall,
                          input bit exp_cas, input logic [63:0] exp_swap,
                          input logic [1:0] exp_stat, input logic [5:0] exp_code,
                          input logic [63:0] exp_out);
    bit saw_cas = 0, got_done = 0;
    int wait_n = 0;
    logic [63:0] cmp_s = '0, swp_s = '0;
    @(negedge clk);
    desc_in = d; eval_valid = 1'b1;
    @(negedge clk);
    eval_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      cas_resp_valid = 1'b0;
      if (done_valid) begin got_done = 1; break; end
      if (cas_ready) begin
        cas_ready = 1'b0; cas_resp_valid = 1'b1; cas_resp_match = match;
      end else if (cas_valid) begin
        chk(eval_ready == 1'b0, {req, " R11 busy"}, 64'(eval_ready), 64'd0);
        if (!saw_cas) begin saw_cas = 1; cmp_s = cas_compare; swp_s = cas_swap; end
        else chk(cas_swap == swp_s, {req, " R11 hold"}, cas_swap, swp_s);
        if (wait_n >= stall) cas_ready = 1'b1;
        wait_n++;
      end
      @(negedge clk);
    end
    chk(got_done, {req, " done"}, 64'(got_done), 64'd1);
    chk(saw_cas == exp_cas, {req, " request issued"}, 64'(saw_cas), 64'(exp_cas));
    if (exp_cas) begin
      chk(cmp_s == d, {req, " compare"}, cmp_s, d);
      chk(swp_s == exp_swap, {req, " swap"}, swp_s, exp_swap);
    end
    chk(done_status == exp_stat, {req, " status"}, 64'(done_status), 64'(exp_stat));
    chk(fault_code == exp_code, {req, " code"}, 64'(fault_code), 64'(exp_code));
    chk(result_desc == exp_out, {req, " result"}, result_desc, exp_out);
    @(negedge clk);
    chk(eval_ready == 1'b1, {req, " R11 idle again"}, 64'(eval_ready), 64'd1);
  endtask

  task automatic t_reset;
    chk(eval_ready == 1'b1, "reset eval_ready", 64'(eval_ready), 64'd1);
    chk(cas_valid == 1'b0, "reset cas_valid", 64'(cas_valid), 64'd0);
    chk(done_valid == 1'b0, "reset done_valid", 64'(done_valid), 64'd0);
  endtask

  task automatic t_r1_cache;
    logic [1:0] ia [6] = '{2'b01, 2'b11, 2'b01, 2'b10, 2'b00, 2'b11};
    logic [1:0] oa [6] = '{2'b01, 2'b11, 2'b11, 2'b01, 2'b01, 2'b10};
    logic       ex [6] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    for (int i = 0; i < 6; i++) begin
      inner_attr = ia[i]; outer_attr = oa[i];
      #1;
      chk(walk_from_cache == ex[i], "R1 cache lookup", 64'(walk_from_cache), 64'(ex[i]));
    end
  endtask

  task automatic t_r2_af_set;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R2 af set s1", BASE, 1, 0, 1, BASE | AF, 2'd0, 6'd0, BASE | AF);
    set_cfg(2'b11, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_case("R2 af set s2 nwa", BASE | WP, 1, 0, 1, BASE | WP | AF, 2'd0, 6'd0, BASE | WP | AF);
  endtask

  task automatic t_r3_af_fault;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case("R3 af fault", BASE, 1, 0, 0, '0, 2'd2, 6'b001011, BASE);
  endtask

  task automatic t_r4_s1_dirty;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_case("R4 s1 dirty", BASE | AF | DBM | WP, 1, 0, 1, BASE | AF | DBM, 2'd0, 6'd0, BASE | AF | DBM);
  endtask

  task automatic t_r5_s2_dirty;
    set_cfg(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case("R5 s2 dirty", BASE | AF | DBM, 1, 0, 1, BASE | AF | DBM | WP, 2'd0, 6'd0, BASE | AF | DBM | WP);
  endtask

  task automatic t_r6_r7_perm;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_case("R6 dirty without af", BASE | AF | DBM | WP, 1, 0, 0, '0, 2'd2, 6'b001111, BASE | AF | DBM | WP);
    set_cfg(2'b01, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case("R7 no modifier", BASE | AF, 1, 0, 0, '0, 2'd2, 6'b001111, BASE | AF);
  endtask

  task automatic t_r8_unsup;
    set_cfg(2'b10, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R8 write-through", BASE, 1, 0, 0, '0, 2'd2, 6'b110001, BASE);
    set_cfg(2'b01, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_case("R8 non-cacheable", BASE | AF | DBM, 1, 0, 0, '0, 2'd2, 6'b110001, BASE | AF | DBM);
  endtask

  task automatic t_r9_nochange;
    set_cfg(2'b00, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    run_case("R9 read af set", BASE | AF | WP, 1, 0, 0, '0, 2'd0, 6'd0, BASE | AF | WP);
    set_cfg(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_case("R9 writable", BASE | AF | DBM, 1, 0, 0, '0, 2'd0, 6'd0, BASE | AF | DBM);
  endtask

  task automatic t_r10_mismatch;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case("R10 mismatch", BASE, 0, 0, 1, BASE | AF, 2'd1, 6'd0, BASE);
  endtask

  task automatic t_r11_stall;
    set_cfg(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    run_case("R11 stall", BASE | DBM | WP, 1, 4, 1, BASE | DBM | AF, 2'd0, 6'd0, BASE | DBM | AF);
  endtask

  initial begin
    bit timed_out = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_r1_cache();
        t_r2_af_set();
        t_r3_af_fault();
        t_r4_s1_dirty();
        t_r5_s2_dirty();
        t_r6_r7_perm();
        t_r8_unsup();
        t_r9_nochange();
        t_r10_mismatch();
        t_r11_stall();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog", 64'd1, 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule